// File: doc/BRIEF.md
# General-purpose compare timer

This block is a memory-mapped up-counting timer. One of several tick-enable inputs is chosen by a clock-source field in the control register. The ticks of that input are divided by a programmable prescaler, and each divided step advances the counter by one. Three compare channels each raise a status flag when the counter reaches their value. A rollover flag marks the counter wrapping from its all-ones value back to zero.

In restart mode, compare channel 1 sets the period: the counter returns to zero on the step after it equals that value. In free-run mode the counter uses its full range. Event flags are cleared by writing a one to them, and each flag can be enabled to drive a single level interrupt. That interrupt is also gated by the global enable bit. A software-reset bit in the control register returns most of the block to its reset state but keeps the enable, mode and clock-source settings.

The register bus is a plain word-addressed port that accepts a read or a write on every cycle. It has no back-pressure and never stalls. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `cmp_timer`

## Requirements
- R1: After hardware reset, the control, prescaler, status, interrupt-enable, counter and capture registers read 0, and all three compare registers read all ones (the counter width set to one).
- R2: Word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture (always read 0), 9 counter. Values narrower than 32 bits read zero-extended. Any other offset reads 0, and a write to it changes no register.
- R3: The counter advances once per (prescaler + 1) ticks of the selected source. The prescaler register keeps only its low 12 bits.
- R4: Control bits 8:6 select the source: code k (1 to 7) uses tick_in[k], and code 0 means no clock, so the counter holds. Ticks on unselected inputs have no effect.
- R5: Restart mode (control bit 9 clear): on a step while the counter equals compare 1, the counter becomes 0. Otherwise the counter increments.
- R6: Free-run mode (control bit 9 set): the counter counts up to all ones and then wraps to 0. A step taken from all ones sets status bit 5 (rollover).
- R7: A step that makes the counter equal to compare 1, 2 or 3 sets status bit 0, 1 or 2 respectively. Status bits 3 and 4 are never set.
- R8: Writing status clears each flag whose written bit (5:0) is 1 and leaves the others unchanged. If a new event for a flag arrives in the same cycle as its clear, the flag stays set.
- R9: The interrupt-enable register keeps bits 5:0. irq is high exactly when (status AND enable) is nonzero and control bit 0 (enable) is set.
- R10: In restart mode, a write to compare 1 resets the counter to 0. In free-run mode, the same write leaves the counter unchanged.
- R11: When enable (bit 0) goes from 0 to 1 with enable-mode (bit 1) set, the counter restarts from 0. Without enable-mode, it resumes from its held value. While enable is 0 the counter is frozen.
- R12: A control write with bit 15 set performs a soft reset: it has the same effect as R1, except that written bits 0, 1, 3 (wait), 5 (stop), 8:6, 16 (doze) and 17 (debug) are kept. Bit 15 reads back 0.
- R13: Control bits 2, 4 and 10 to 15 cannot be written and read 0. All other control bits read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data valid the next cycle |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_in | input | 8 | Tick enables, indexed by source code (bit 0 unused) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with an 8-bit counter and the default 12-bit prescaler. With that counter width, the all-ones wrap and the rollover flag are reached within a few hundred ticks. It sweeps every non-zero source code against prescaler values 0 to 3, with all other tick inputs toggling. It also walks the restart period one step at a time, which brings the period boundary, the clear-versus-event collision and the soft-reset retention rules within a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_DW  = 32;
  localparam int SRC_W   = 3;
  localparam int NSRC    = 1 << SRC_W;
  localparam int NFLAG   = 6;
  localparam int NCMP    = 3;

  localparam int OFS_CTRL = 0;
  localparam int OFS_PRE  = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_IER  = 3;
  localparam int OFS_CMP0 = 4;
  localparam int OFS_CAP0 = 7;
  localparam int OFS_CAP1 = 8;
  localparam int OFS_CNT  = 9;

  localparam int CB_EN    = 0;
  localparam int CB_ENMOD = 1;
  localparam int CB_SRC   = 6;
  localparam int CB_FRR   = 9;
  localparam int CB_SWR   = 15;

  localparam int FL_ROV   = 5;

  // storable control bits (2, 4, 10..15 dropped)
  localparam logic [TMR_DW-1:0] CTRL_WMASK = 32'hFFFF_03EB;
  // bits retained across soft reset
  localparam logic [TMR_DW-1:0] CTRL_KEEP  = 32'h0003_01EB;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SRC_W-1:0] src,
  input  logic [NSRC-1:0]  tick_in,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (src == '0) ? 1'b0 : tick_in[src];
  assign step = run && tick && (pre_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr || step) begin
      pre_q <= '0;
    end else if (run && tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic                       clr,
  input  logic                       free_run,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCMP-1:0]            hit,
  output logic                       wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_max;
  logic             at_period;
  logic             adv;

  assign adv       = step && !clr;
  assign at_max    = (cnt_q == CNT_MAX);
  assign at_period = !free_run && (cnt_q == cmp[0]);
  assign cnt_nxt   = (at_max || at_period) ? '0 : cnt_q + 1'b1;
  assign wrap      = adv && at_max;
  assign cnt       = cnt_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign hit[i] = adv && (cnt_nxt == cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             en,
  input logic [NFLAG-1:0] ier,
  input logic [NFLAG-1:0] status,
  input logic [CNT_W-1:0] cnt,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));

  assert_cnt_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  assert_rov_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[FL_ROV]) |-> ($past(cnt) == CNT_MAX));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0 || !en) |-> !irq);
endmodule

bind cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (bus_wr),
  .en    (ctrl_q[0]),
  .ier   (ier_q),
  .status(status_q),
  .cnt   (cnt_q),
  .irq   (irq)
);

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TMR_DW-1:0] bus_wdata,
  output logic [TMR_DW-1:0] bus_rdata,
  input  logic [NSRC-1:0]   tick_in,
  output logic              irq
);
  logic [TMR_DW-1:0]          ctrl_q;
  logic [PRE_W-1:0]           pre_q;
  logic [NFLAG-1:0]           status_q;
  logic [NFLAG-1:0]           ier_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [NCMP-1:0]            hit;
  logic                       wrap;
  logic                       step;

  logic wr_ctrl, wr_pre, wr_stat, wr_ier;
  logic [NCMP-1:0] wr_cmp;
  logic soft_rst, en_rise, cnt_clr;
  logic [NFLAG-1:0] evt, clr_mask;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_pre  = bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ier  = bus_wr && (bus_addr == ADDR_W'(OFS_IER));

  for (genvar i = 0; i < NCMP; i++) begin : g_wcmp
    assign wr_cmp[i] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP0 + i));
  end

  assign soft_rst = wr_ctrl && bus_wdata[CB_SWR];
  assign en_rise  = wr_ctrl && !bus_wdata[CB_SWR] && bus_wdata[CB_EN] &&
                    bus_wdata[CB_ENMOD] && !ctrl_q[CB_EN];
  assign cnt_clr  = soft_rst || en_rise || (wr_cmp[0] && !ctrl_q[CB_FRR]);

  assign evt      = {wrap, 2'b00, hit};
  assign clr_mask = wr_stat ? bus_wdata[NFLAG-1:0] : '0;
  assign irq      = ctrl_q[CB_EN] && ((status_q & ier_q) != '0);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q[CB_EN]),
    .clr    (cnt_clr),
    .src    (ctrl_q[CB_SRC +: SRC_W]),
    .tick_in(tick_in),
    .div    (pre_q),
    .step   (step)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .clr     (cnt_clr),
    .free_run(ctrl_q[CB_FRR]),
    .cmp     (cmp_q),
    .cnt     (cnt_q),
    .hit     (hit),
    .wrap    (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      status_q <= '0;
      ier_q    <= '0;
      cmp_q    <= '1;
    end else if (soft_rst) begin
      ctrl_q   <= bus_wdata & CTRL_KEEP;
      pre_q    <= '0;
      status_q <= '0;
      ier_q    <= '0;
      cmp_q    <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
      if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (wr_ier)  ier_q  <= bus_wdata[NFLAG-1:0];
      for (int i = 0; i < NCMP; i++) begin
        if (wr_cmp[i]) cmp_q[i] <= bus_wdata[CNT_W-1:0];
      end
      status_q <= (status_q & ~clr_mask) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if      (bus_addr == ADDR_W'(OFS_CTRL))     bus_rdata <= ctrl_q;
      else if (bus_addr == ADDR_W'(OFS_PRE))      bus_rdata <= TMR_DW'(pre_q);
      else if (bus_addr == ADDR_W'(OFS_STAT))     bus_rdata <= TMR_DW'(status_q);
      else if (bus_addr == ADDR_W'(OFS_IER))      bus_rdata <= TMR_DW'(ier_q);
      else if (bus_addr == ADDR_W'(OFS_CMP0))     bus_rdata <= TMR_DW'(cmp_q[0]);
      else if (bus_addr == ADDR_W'(OFS_CMP0 + 1)) bus_rdata <= TMR_DW'(cmp_q[1]);
      else if (bus_addr == ADDR_W'(OFS_CMP0 + 2)) bus_rdata <= TMR_DW'(cmp_q[2]);
      else if (bus_addr == ADDR_W'(OFS_CNT))      bus_rdata <= TMR_DW'(cnt_q);
      else                                        bus_rdata <= '0;
    end
  end
endmodule

// File: tb/sim_cmp_timer.sv
`timescale 1ns/100ps
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tick_in = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  cmp_timer #(.CNT_W(8), .PRE_W(12), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tick(input logic [7:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = m;
      @(negedge clk);
    end
    tick_in = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 map
    rdchk("R1 ctrl", 0, 0);
    rdchk("R1 pre", 1, 0);
    rdchk("R1 status", 2, 0);
    rdchk("R1 ier", 3, 0);
    rdchk("R1 cmp1", 4, 32'hFF);
    rdchk("R1 cmp2", 5, 32'hFF);
    rdchk("R1 cmp3", 6, 32'hFF);
    rdchk("R1 cap1", 7, 0);
    rdchk("R1 cap2", 8, 0);
    rdchk("R1 cnt", 9, 0);

    // R2 unmapped offset
    wr(11, 32'hFFFF_FFFF);
    rdchk("R2 unmapped read", 11, 0);
    rdchk("R2 ctrl untouched", 0, 0);
    rdchk("R2 pre untouched", 1, 0);
    rdchk("R2 cmp1 untouched", 4, 32'hFF);
    wr(7, 32'h1234_5678);
    rdchk("R2 capture reads zero", 7, 0);

    // R13 control write mask
    wr(0, 32'hFFFF_7FFF);
    rdchk("R13 ctrl mask", 0, 32'hFFFF_03EB);
    wr(0, 0);

    // R3 prescaler width
    wr(1, 32'hFFFF_F003);
    rdchk("R3 pre low bits", 1, 32'h003);

    // R3/R4 sweep
    for (int s = 1; s < 8; s++) begin
      for (int d = 0; d < 4; d++) begin
        wr(0, 0);
        wr(1, 32'(d));
        wr(0, 32'h203 | (32'(s) << 6));
        tick(~(8'd1 << s), 5);
        tick(8'd1 << s, 7);
        rdchk($sformatf("R3 R4 src=%0d div=%0d", s, d), 9, 32'(7 / (d + 1)));
      end
    end
    wr(0, 0);
    wr(1, 0);
    wr(0, 32'h203);
    tick(8'hFF, 5);
    rdchk("R4 source zero holds", 9, 0);

    // R5 restart period
    wr(0, 0);
    wr(3, 0);
    wr(4, 5);
    wr(2, 32'h3F);
    wr(0, 32'h43);
    for (int k = 1; k <= 13; k++) begin
      tick(8'h02, 1);
      rdchk($sformatf("R5 step %0d", k), 9, 32'(k % 6));
    end
    rdchk("R7 cmp1 flag", 2, 32'h01);

    // R8 w1c
    wr(2, 32'h3E);
    rdchk("R8 zero bits keep", 2, 32'h01);
    wr(2, 32'h01);
    rdchk("R8 one clears", 2, 32'h00);
    tick(8'h02, 3);
    rdchk("R8 cnt before collide", 9, 4);
    tick_in = 8'h02; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h01;
    @(negedge clk);
    tick_in = 8'h00; bus_wr = 1'b0;
    rdchk("R8 event wins", 2, 32'h01);
    rdchk("R8 cnt at period", 9, 5);

    // R9 interrupt
    wr(3, 32'hFFFF_FFC1);
    rdchk("R9 ier mask", 3, 32'h01);
    chk("R9 irq on", 32'(irq), 1);
    wr(0, 32'h42);
    chk("R9 irq gated by enable", 32'(irq), 0);
    wr(0, 32'h43);
    chk("R9 irq back", 32'(irq), 1);
    rdchk("R11 enmod restart", 9, 0);
    wr(2, 32'h3F);
    chk("R9 irq cleared", 32'(irq), 0);

    // R7 compare 2/3
    wr(5, 2);
    wr(6, 3);
    tick(8'h02, 3);
    rdchk("R7 cnt", 9, 3);
    rdchk("R7 cmp2 cmp3 flags", 2, 32'h06);

    // R10
    wr(4, 5);
    rdchk("R10 restart write clears", 9, 0);
    wr(0, 32'h243);
    tick(8'h02, 2);
    wr(4, 5);
    rdchk("R10 free-run write keeps", 9, 2);

    // R6 rollover
    wr(2, 32'h3F);
    tick(8'h02, 253);
    rdchk("R6 reach max", 9, 32'hFF);
    rdchk("R6 flags before wrap", 2, 32'h05);
    tick(8'h02, 1);
    rdchk("R6 wrap to zero", 9, 0);
    rdchk("R6 rollover flag", 2, 32'h25);

    // R11 freeze and resume
    tick(8'h02, 3);
    wr(0, 32'h242);
    tick(8'h02, 5);
    rdchk("R11 frozen", 9, 3);
    wr(0, 32'h241);
    tick(8'h02, 1);
    rdchk("R11 resume without enmod", 9, 4);
    wr(0, 32'h240);
    wr(0, 32'h243);
    rdchk("R11 restart with enmod", 9, 0);

    // R12 soft reset
    wr(1, 2);
    wr(3, 32'h21);
    wr(5, 7);
    tick(8'h02, 3);
    wr(0, 32'h0013_826B);
    rdchk("R12 ctrl kept bits", 0, 32'h0003_006B);
    rdchk("R12 pre", 1, 0);
    rdchk("R12 status", 2, 0);
    rdchk("R12 ier", 3, 0);
    rdchk("R12 cmp2", 5, 32'hFF);
    rdchk("R12 cnt", 9, 0);
    chk("R12 irq", 32'(irq), 0);
    tick(8'h02, 2);
    rdchk("R12 still enabled", 9, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule